// File: doc/BRIEF.md
# Synchronous Burst SRAM with Address-Strobe Control

This block is a clocked static memory of 256 words of 32 bits, split into four 8-bit byte lanes, with a shared bidirectional data bus. Every rising clock edge is classified from the three chip selects, a sleep input, two address strobes, a burst step input and the write controls. The possible actions are: sleep, deselect, load an external address and start a burst (read or write), step the burst to its next address, or stay on the current burst address.

The two address strobes follow different rules. The host strobe (`host_strb_n`) wins when the chip is selected and always starts a read. The controller strobe (`ctrl_strb_n`) loads an address for either a read or a write. The burst counter covers the two low address bits and wraps inside a group of four. `ilv_order` selects linear or interleaved ordering.

Reads are pipelined. Data captured from the array appears on the bus one cycle after the address edge. The bus is driven only while the asynchronous output enable is low.

Top module: `sbsram_core`

## Requirements
- R1: While `sleep` is high, the bus is released at once, without waiting for a clock edge. No write takes place and the burst address is left unchanged.
- R2: An edge is a deselect when either of these holds: `ctrl_strb_n` is low with `sel_a_n` high, `sel_b` low or `sel_c_n` high; or `host_strb_n` is low with `sel_a_n` low and `sel_b` low or `sel_c_n` high. A deselect writes nothing, and its output stage leaves the bus undriven.
- R3: `host_strb_n` low with `sel_a_n` low, `sel_b` high and `sel_c_n` low starts a read at `addr`. This holds even when `ctrl_strb_n` is also low, and `all_wr_n`, `lane_wr_n` and `lane_en_n` have no effect on that edge.
- R4: `ctrl_strb_n` low with `host_strb_n` high and the chip selected loads `addr` as the burst start. The edge is a write if the write request is active and a read otherwise.
- R5: With both strobes high and `step_n` low, the burst moves to its next address and the write request decides between read and write. The offset wraps modulo 4 inside the group of four.
- R6: With both strobes high and `step_n` high, the current burst address is used again for a read or a write.
- R7: While `sel_a_n` is high, `host_strb_n` is ignored. With `ctrl_strb_n` high, the step and hold rules of R5 and R6 still apply.
- R8: The write request is active when `all_wr_n` is low, which writes all four lanes. It is also active when `lane_wr_n` is low and at least one `lane_en_n[k]` is low; only lanes k with `lane_en_n[k]` low are written, where lane k is `data_io[8k+7:8k]`. With `all_wr_n`, `lane_wr_n` and all `lane_en_n` high, the cycle is a read.
- R9: Burst beat k (k = 0..3) from start offset s uses low address bits (s + k) mod 4 when `ilv_order` = 0, and s XOR k when `ilv_order` = 1. Beat 0 is the loaded address.
- R10: Data read on edge N is driven on the bus from edge N+1 until edge N+2, only while `out_en_n` is low. `out_en_n` acts combinationally, without waiting for a clock edge.
- R11: The output stage of a write cycle leaves the bus undriven, even with `out_en_n` low.
- R12: After synchronous reset, the bus is undriven, and the burst address is 0 with beat count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Power-down: releases the bus, ignores all other inputs |
| sel_a_n | input | 1 | Primary chip select, active low |
| sel_b | input | 1 | Secondary chip select, active high |
| sel_c_n | input | 1 | Tertiary chip select, active low |
| host_strb_n | input | 1 | Host address strobe (read only, priority) |
| ctrl_strb_n | input | 1 | Controller address strobe (read or write) |
| step_n | input | 1 | Burst step (low) or hold (high) |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Enables per-lane writes, active low |
| lane_en_n | input | 4 | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | 8 | External word address |
| data_io | inout | 32 | Bidirectional data bus |

## Verification
A vector table walks the controller strobe into a four-beat write burst that wraps. It follows with hold-address lane writes, then host-strobe reads that carry active write controls. Comparing the values read back shows whether an edge stepped, held or wrapped, and whether it wrote or only read. Deselects of each kind are placed just before reads of the address they would have damaged, so a stray write and a driven output stage each give a different wrong value. Directed sequences cover interleaved order against linear readback, toggling the output enable in mid-cycle, and a write attempted during sleep, followed by a hold read that shows the saved burst position.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int unsigned DEF_ADDR_W = 8;
    localparam int unsigned DEF_LANES  = 4;
    localparam int unsigned DEF_LANE_W = 8;
    localparam int unsigned BURST_W    = 2;

    typedef enum logic [2:0] {
        CYC_SLEEP,
        CYC_DESEL,
        CYC_LOAD_RD,
        CYC_LOAD,
        CYC_NEXT,
        CYC_HOLD
    } cyc_e;

    typedef struct packed {
        cyc_e kind;
        logic write;
    } cyc_ctl_t;

    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input logic               ilv
    );
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

    function automatic logic is_load(input cyc_e k);
        return (k == CYC_LOAD) || (k == CYC_LOAD_RD);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES
) (
    input  logic             sleep,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             host_strb_n,
    input  logic             ctrl_strb_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_en_n,
    output cyc_ctl_t         ctl,
    output logic [LANES-1:0] wr_mask
);

    logic [LANES-1:0] req_mask;
    logic             chip_on;
    logic             wr_capable;

    for (genvar g = 0; g < LANES; g++) begin : g_lane_req
        assign req_mask[g] = ~all_wr_n | (~lane_wr_n & ~lane_en_n[g]);
    end

    assign chip_on = sel_b & ~sel_c_n;

    always_comb begin
        ctl.kind = CYC_HOLD;
        if (sleep) begin
            ctl.kind = CYC_SLEEP;
        end else if (!host_strb_n && !sel_a_n) begin
            ctl.kind = chip_on ? CYC_LOAD_RD : CYC_DESEL;
        end else if (!ctrl_strb_n) begin
            ctl.kind = (!sel_a_n && chip_on) ? CYC_LOAD : CYC_DESEL;
        end else begin
            ctl.kind = step_n ? CYC_HOLD : CYC_NEXT;
        end
    end

    assign wr_capable = (ctl.kind == CYC_LOAD) || (ctl.kind == CYC_NEXT) ||
                        (ctl.kind == CYC_HOLD);
    assign ctl.write  = wr_capable & (|req_mask);
    assign wr_mask    = ctl.write ? req_mask : '0;

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_e              kind,
    input  logic              ilv_order,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] eff_addr
);

    localparam int unsigned HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q, base_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;
    logic [HI_W-1:0]    base_hi;
    logic [BURST_W-1:0] base_lo;

    assign base_hi = base_q[ADDR_W-1:BURST_W];
    assign base_lo = base_q[BURST_W-1:0];

    always_comb begin
        base_d   = base_q;
        cnt_d    = cnt_q;
        eff_addr = {base_hi, burst_offset(base_lo, cnt_q, ilv_order)};
        unique case (kind)
            CYC_LOAD, CYC_LOAD_RD: begin
                base_d   = ext_addr;
                cnt_d    = '0;
                eff_addr = ext_addr;
            end
            CYC_NEXT: begin
                cnt_d    = cnt_q + 1'b1;
                eff_addr = {base_hi, burst_offset(base_lo, cnt_d, ilv_order)};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    AST_SLEEP_HOLDS_BURST: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_SLEEP) |=> ($stable(base_q) && $stable(cnt_q))); // R1
    AST_LOAD_RESTARTS_BURST: assert property (@(posedge clk) disable iff (rst)
        is_load(kind) |=> ((cnt_q == '0) && (base_q == $past(ext_addr)))); // R4
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_NEXT) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1))); // R5
    AST_HOLD_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_HOLD) |=> ($stable(cnt_q) && $stable(base_q))); // R6

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sleep,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    host_strb_n,
    input  logic                    ctrl_strb_n,
    input  logic                    step_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic                    out_en_n,
    input  logic                    ilv_order,
    input  logic [ADDR_W-1:0]       addr,
    inout  wire  [LANES*LANE_W-1:0] data_io
);

    localparam int unsigned DATA_W = LANES * LANE_W;

    cyc_ctl_t          ctl;
    logic [LANES-1:0]  wr_mask;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_pend_q;
    logic              out_valid_q;
    logic [DATA_W-1:0] out_data_q;
    logic [DATA_W-1:0] rd_word;
    logic              take_read;
    logic              bus_drive;

    sbsram_decode #(.LANES(LANES)) u_decode (
        .sleep       (sleep),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .host_strb_n (host_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .step_n      (step_n),
        .all_wr_n    (all_wr_n),
        .lane_wr_n   (lane_wr_n),
        .lane_en_n   (lane_en_n),
        .ctl         (ctl),
        .wr_mask     (wr_mask)
    );

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .kind      (ctl.kind),
        .ilv_order (ilv_order),
        .ext_addr  (addr),
        .eff_addr  (eff_addr)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_mask (wr_mask),
        .wr_addr (eff_addr),
        .wr_data (data_io),
        .rd_addr (rd_addr_q),
        .rd_data (rd_word)
    );

    assign take_read = (ctl.kind == CYC_LOAD_RD) ||
                       (((ctl.kind == CYC_LOAD) || (ctl.kind == CYC_NEXT) ||
                         (ctl.kind == CYC_HOLD)) && !ctl.write);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend_q   <= 1'b0;
            rd_addr_q   <= '0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            rd_pend_q   <= take_read;
            if (take_read) begin
                rd_addr_q <= eff_addr;
            end
            out_valid_q <= rd_pend_q;
            if (rd_pend_q) begin
                out_data_q <= rd_word;
            end
        end
    end

    assign bus_drive = out_valid_q & ~out_en_n & ~sleep;
    assign data_io   = bus_drive ? out_data_q : 'z;

    AST_SLEEP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (wr_mask == '0)); // R1
    AST_DESEL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !ctrl_strb_n && (sel_a_n || !sel_b || sel_c_n)) |-> (wr_mask == '0)); // R2
    AST_HOST_STROBE_READS: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !host_strb_n && !sel_a_n) |-> (wr_mask == '0)); // R3
    AST_SEL_A_OFF_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (!sleep && sel_a_n && ctrl_strb_n) |->
        ((ctl.kind == CYC_NEXT) || (ctl.kind == CYC_HOLD))); // R7
    AST_WRITE_STAGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ctl.write |=> ##1 !out_valid_q); // R11
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid_q && !rd_pend_q)); // R12

endmodule

// File: tb/tb_sbsram_core.sv
module tb_sbsram_core;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 5000;
    localparam logic [31:0] FLOAT = 32'hFFFF_FFFF; // pulled-up, undriven bus

    typedef struct packed {
        logic [2:0]  sel;   // {sel_a_n, sel_b, sel_c_n}
        logic [2:0]  strb;  // {host_strb_n, ctrl_strb_n, step_n}
        logic [5:0]  wr;    // {all_wr_n, lane_wr_n, lane_en_n[3:0]}
        logic        oe_n;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic        chk;
        logic [3:0]  req;
        logic [31:0] exp;   // bus one cycle after the read edge
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        // R4 load write at 0x10, then R5 steps and wrap back to 0x10 with sel_a_n high (R7)
        '{3'b010, 3'b101, 6'b011111, 1'b1, 8'h10, 32'hA0A0_0010, 1'b0, 4'd0,  FLOAT},
        '{3'b110, 3'b110, 6'b011111, 1'b1, 8'h00, 32'h1111_1111, 1'b0, 4'd0,  FLOAT},
        '{3'b110, 3'b110, 6'b011111, 1'b1, 8'h00, 32'h2222_2222, 1'b0, 4'd0,  FLOAT},
        '{3'b110, 3'b110, 6'b011111, 1'b1, 8'h00, 32'h3333_3333, 1'b0, 4'd0,  FLOAT},
        '{3'b110, 3'b110, 6'b011111, 1'b1, 8'h00, 32'h4444_4444, 1'b0, 4'd0,  FLOAT},
        // R6 / R8: hold address, lane 0 only
        '{3'b110, 3'b111, 6'b101110, 1'b1, 8'h00, 32'h5555_55AA, 1'b0, 4'd0,  FLOAT},
        // R8: lane enables low but lane_wr_n high -> read
        '{3'b110, 3'b111, 6'b110000, 1'b1, 8'h00, 32'h0,         1'b1, 4'd8,  32'h4444_44AA},
        // R3: host strobe read with all_wr_n low
        '{3'b010, 3'b011, 6'b011111, 1'b0, 8'h12, 32'hDEAD_BEEF, 1'b1, 4'd3,  32'h2222_2222},
        '{3'b110, 3'b110, 6'b111111, 1'b0, 8'h00, 32'h0,         1'b1, 4'd5,  32'h3333_3333},
        '{3'b110, 3'b110, 6'b111111, 1'b0, 8'h00, 32'h0,         1'b1, 4'd5,  32'h4444_44AA},
        // R10: next vector has out_en_n high
        '{3'b110, 3'b111, 6'b111111, 1'b0, 8'h00, 32'h0,         1'b1, 4'd10, FLOAT},
        // R2: ctrl strobe with sel_a_n high -> deselect, must not write 0x11
        '{3'b110, 3'b101, 6'b011111, 1'b1, 8'h11, 32'h9999_9999, 1'b1, 4'd2,  FLOAT},
        '{3'b010, 3'b011, 6'b111111, 1'b0, 8'h11, 32'h0,         1'b1, 4'd2,  32'h1111_1111},
        // R7: host strobe low, sel_a_n high, ctrl high, step -> 0x12
        '{3'b110, 3'b010, 6'b111111, 1'b0, 8'h00, 32'h0,         1'b1, 4'd7,  32'h2222_2222},
        // R2: sel_b low deselect
        '{3'b000, 3'b101, 6'b011111, 1'b0, 8'h20, 32'h7777_7777, 1'b0, 4'd0,  FLOAT},
        '{3'b010, 3'b101, 6'b011111, 1'b1, 8'h21, 32'h0102_0304, 1'b0, 4'd0,  FLOAT},
        // R11: lane write stage, then out_en_n low -> undriven
        '{3'b110, 3'b111, 6'b100101, 1'b1, 8'h00, 32'hAABB_CCDD, 1'b1, 4'd11, FLOAT},
        // R4 / R8: ctrl strobe read back of lanes 3 and 1
        '{3'b010, 3'b101, 6'b111111, 1'b0, 8'h21, 32'h0,         1'b1, 4'd4,  32'hAA02_CC04},
        // R3: both strobes low -> host read wins
        '{3'b010, 3'b001, 6'b011111, 1'b0, 8'h10, 32'h0,         1'b1, 4'd3,  32'h4444_44AA},
        // R2: sel_c_n high with host strobe
        '{3'b011, 3'b011, 6'b111111, 1'b0, 8'h00, 32'h0,         1'b1, 4'd2,  FLOAT},
        '{3'b110, 3'b101, 6'b111111, 1'b0, 8'h00, 32'h0,         1'b0, 4'd0,  FLOAT}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        sleep;
    logic        sel_a_n, sel_b, sel_c_n;
    logic        host_strb_n, ctrl_strb_n, step_n;
    logic        all_wr_n, lane_wr_n;
    logic [3:0]  lane_en_n;
    logic        out_en_n;
    logic        ilv_order;
    logic [7:0]  addr;
    logic        tb_drv;
    logic [31:0] tb_data;
    tri1  [31:0] bus;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    assign bus = tb_drv ? tb_data : 'z;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sbsram_core dut (
        .clk         (clk),
        .rst         (rst),
        .sleep       (sleep),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .host_strb_n (host_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .step_n      (step_n),
        .all_wr_n    (all_wr_n),
        .lane_wr_n   (lane_wr_n),
        .lane_en_n   (lane_en_n),
        .out_en_n    (out_en_n),
        .ilv_order   (ilv_order),
        .addr        (addr),
        .data_io     (bus)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive(input logic [2:0] sel, input logic [2:0] strb,
                         input logic [5:0] wr, input logic oe, input logic [7:0] a,
                         input logic [31:0] wd);
        {sel_a_n, sel_b, sel_c_n}            = sel;
        {host_strb_n, ctrl_strb_n, step_n}   = strb;
        {all_wr_n, lane_wr_n, lane_en_n}     = wr;
        out_en_n = oe;
        addr     = a;
        tb_data  = wd;
        tb_drv   = oe && (!wr[5] || !wr[4]);
    endtask

    task automatic look(input string req, input logic [31:0] exp);
        tb_drv = 1'b0;
        #1;
        checks++;
        if (bus !== exp) begin
            errors++;
            $display("FAIL %s: bus=%h expected %h", req, bus, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected completion", MAX_CYCLES);
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        sleep = 1'b0;
        ilv_order = 1'b0;
        drive(3'b110, 3'b111, 6'b111111, 1'b0, 8'h00, 32'h0);
        repeat (3) tick();
        rst = 1'b0;

        // R12: reset leaves bus undriven and burst at address 0
        look("R12", FLOAT);
        drive(3'b110, 3'b111, 6'b011111, 1'b1, 8'h55, 32'hCAFE_0001);
        tick();
        drive(3'b010, 3'b011, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        drive(3'b110, 3'b101, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        look("R12", 32'hCAFE_0001);

        // table walk: vector j is checked two iterations later
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2 && VEC[i-2].chk)
                look($sformatf("R%0d vec%0d", VEC[i-2].req, i - 2), VEC[i-2].exp);
            if (i < NV)
                drive(VEC[i].sel, VEC[i].strb, VEC[i].wr, VEC[i].oe_n, VEC[i].addr, VEC[i].wd);
            else
                drive(3'b110, 3'b101, 6'b111111, 1'b0, 8'h00, 32'h0);
            tick();
        end

        // R10: asynchronous output enable inside one cycle
        drive(3'b010, 3'b011, 6'b111111, 1'b0, 8'h10, 32'h0);
        tick();
        drive(3'b110, 3'b110, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        look("R10", 32'h4444_44AA);
        out_en_n = 1'b1;
        look("R10", FLOAT);
        out_en_n = 1'b0;
        look("R10", 32'h4444_44AA);
        drive(3'b110, 3'b101, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();

        // R1: sleep releases bus at once, blocks writes, keeps burst at 0x11
        sleep = 1'b1;
        look("R1", FLOAT);
        drive(3'b010, 3'b101, 6'b011111, 1'b1, 8'h21, 32'h0BAD_0BAD);
        tick();
        tick();
        sleep = 1'b0;
        drive(3'b110, 3'b111, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        drive(3'b110, 3'b101, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        look("R1", 32'h1111_1111);
        drive(3'b010, 3'b011, 6'b111111, 1'b0, 8'h21, 32'h0);
        tick();
        drive(3'b110, 3'b101, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        look("R1", 32'hAA02_CC04);

        // R9: interleaved write burst from 0x31, linear readback from 0x30
        ilv_order = 1'b1;
        drive(3'b010, 3'b101, 6'b011111, 1'b1, 8'h31, 32'hB000_0000);
        tick();
        for (int k = 1; k < 4; k++) begin
            drive(3'b110, 3'b110, 6'b011111, 1'b1, 8'h00, 32'hB000_0000 + k);
            tick();
        end
        ilv_order = 1'b0;
        drive(3'b010, 3'b011, 6'b111111, 1'b0, 8'h30, 32'h0);
        tick();
        drive(3'b110, 3'b110, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        look("R9", 32'hB000_0001);
        drive(3'b110, 3'b110, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        look("R9", 32'hB000_0000);
        drive(3'b110, 3'b110, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        look("R9", 32'hB000_0003);
        drive(3'b110, 3'b101, 6'b111111, 1'b0, 8'h00, 32'h0);
        tick();
        look("R9", 32'hB000_0002);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule